// File: doc/BRIEF.md
# Receive Queue Prefetch Advice Handler

This block sits between a receive queue unit and a cache fill engine. When software dequeues a receive buffer, the queue unit offers the buffer's start address as advice. The handler turns accepted advice into one line fill request, so the first bytes of the buffer are already in the cache when the processor reads them. It keeps a single holding register for advice that is waiting to be filled.

Two configuration inputs shape its behaviour. The first enables the use of advice at all. The second chooses the acknowledge policy. In prompt mode every advice is acknowledged at once and is thrown away if the holding register is occupied. In guaranteed mode the acknowledge is withheld until the advice has been captured. Advice whose line is already resident in the cache, or already waiting in the holding register, is acknowledged and absorbed without a new fill.

Top module: `rxq_prefetch_advice`

## Requirements
- R1: After a synchronous reset, `adv_ack` and `fill_req` are low.
- R2: `adv_ack` is a single-cycle pulse. It is asserted in the cycle after the handler decides on the advice, and the advice is consumed on the clock edge where both `adv_valid` and `adv_ack` are high.
- R3: With `cfg_use_advice` low, presented advice is acknowledged in the next cycle and never causes a fill request, in either acknowledge mode.
- R4: Captured advice raises `fill_req` in the same cycle as `adv_ack`. `fill_addr` equals the advice address with its low log2(LINE_BYTES) bits forced to zero (bits [2:0] for the default 8-byte line).
- R5: `fill_req` stays high with a stable `fill_addr` until `fill_gnt` is sampled high. It drops in the following cycle unless new advice is captured on that same edge.
- R6: In prompt mode (`cfg_hold_ack` low), advice that arrives while a request is pending and not being granted is acknowledged in the next cycle and discarded. The pending `fill_addr` does not change.
- R7: In guaranteed mode (`cfg_hold_ack` high), advice that arrives while the holding register is busy is not acknowledged until the register is freed. It is then captured and filled.
- R8: Advice whose line number equals `res_line` entry i while `res_vld[i]` is high is acknowledged without a fill request. A matching entry whose valid bit is low does not count as resident.
- R9: Advice for the same line as the pending request is acknowledged and absorbed, so only one fill is issued for that line.
- R10: A grant frees the holding register in the same cycle. Advice decided on the grant edge is captured there, and `fill_req` stays high with the new address and no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_use_advice | input | 1 | 1: act on advice; 0: acknowledge and ignore |
| cfg_hold_ack | input | 1 | 1: guaranteed mode (withhold ack until captured); 0: prompt mode |
| adv_valid | input | 1 | Advice offered; held until acknowledged |
| adv_addr | input | ADDR_W | Start byte address of the dequeued buffer |
| adv_ack | output | 1 | Single-cycle advice acknowledge |
| res_vld | input | NUM_LINES | Valid bit per resident cache line |
| res_line | input | NUM_LINES*(ADDR_W-log2(LINE_BYTES)) | Packed resident line numbers, entry i at slice i |
| fill_req | output | 1 | Line fill request |
| fill_addr | output | ADDR_W | Line-aligned fill address |
| fill_gnt | input | 1 | Fill engine accepts the request |

## Verification
The assertions assume the queue unit keeps `adv_valid` high, with a stable address, until it sees `adv_ack`, and lowers it on the edge that completes the handshake. They also assume that `fill_gnt` is only meaningful while `fill_req` is high. The bench driver follows both rules. It raises valid just after an edge and drops it right after the acknowledge cycle, and it pulses the grant for exactly one cycle while a request is pending. The configuration and residency inputs change only while no advice is in flight.

// File: rtl/rxq_pa_pkg.sv
package rxq_pa_pkg;
  typedef enum logic [2:0] {
    ACT_WAIT    = 3'd0,
    ACT_IGNORE  = 3'd1,
    ACT_ABSORB  = 3'd2,
    ACT_CAPTURE = 3'd3,
    ACT_DROP    = 3'd4
  } adv_act_e;
endpackage

// File: rtl/rxq_pa_line_match.sv
module rxq_pa_line_match #(
  parameter int LAW       = 29,
  parameter int NUM_LINES = 2
) (
  input  logic [LAW-1:0]           probe_line,
  input  logic [NUM_LINES-1:0]     res_vld,
  input  logic [NUM_LINES*LAW-1:0] res_line,
  input  logic                     hold_vld,
  input  logic [LAW-1:0]           hold_line,
  output logic                     hit_res,
  output logic                     hit_hold
);
  logic [NUM_LINES-1:0] per_line_hit;

  // One comparator per resident line
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_cmp
    assign per_line_hit[i] = res_vld[i] && (res_line[i*LAW +: LAW] == probe_line);
  end

  assign hit_res  = |per_line_hit;
  assign hit_hold = hold_vld && (hold_line == probe_line);
endmodule

// File: rtl/rxq_pa_decide.sv
module rxq_pa_decide
  import rxq_pa_pkg::*;
(
  input  logic     present,
  input  logic     use_advice,
  input  logic     hold_ack,
  input  logic     hit_res,
  input  logic     hit_hold,
  input  logic     hold_free,
  output adv_act_e act
);
  always_comb begin
    act = ACT_WAIT;
    if (present) begin
      if (!use_advice)            act = ACT_IGNORE;
      else if (hit_res || hit_hold) act = ACT_ABSORB;
      else if (hold_free)         act = ACT_CAPTURE;
      else if (!hold_ack)         act = ACT_DROP;
      else                        act = ACT_WAIT;
    end
  end
endmodule

// File: rtl/rxq_pa_hold_reg.sv
module rxq_pa_hold_reg #(
  parameter int LAW = 29
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           capture,
  input  logic [LAW-1:0] line_in,
  input  logic           gnt,
  output logic           vld,
  output logic [LAW-1:0] line_q,
  output logic           free
);
  // A grant frees the slot in the same cycle
  assign free = !vld || gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
    end else if (capture) begin
      vld <= 1'b1;
    end else if (gnt) begin
      vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
    end else if (capture) begin
      line_q <= line_in;
    end
  end
endmodule

// File: rtl/rxq_prefetch_advice.sv
module rxq_prefetch_advice
  import rxq_pa_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 8,
  parameter int NUM_LINES  = 2,
  localparam int LOFF      = $clog2(LINE_BYTES),
  localparam int LAW       = ADDR_W - LOFF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_use_advice,
  input  logic                     cfg_hold_ack,
  input  logic                     adv_valid,
  input  logic [ADDR_W-1:0]        adv_addr,
  output logic                     adv_ack,
  input  logic [NUM_LINES-1:0]     res_vld,
  input  logic [NUM_LINES*LAW-1:0] res_line,
  output logic                     fill_req,
  output logic [ADDR_W-1:0]        fill_addr,
  input  logic                     fill_gnt
);
  logic           ack_q;
  logic           present;
  logic           hit_res, hit_hold;
  logic           hold_vld, hold_free;
  logic [LAW-1:0] hold_line;
  logic [LAW-1:0] probe_line;
  adv_act_e       act;

  assign probe_line = adv_addr[ADDR_W-1:LOFF];
  // Advice is decided only once, before its acknowledge is raised
  assign present    = adv_valid && !ack_q;

  rxq_pa_line_match #(.LAW(LAW), .NUM_LINES(NUM_LINES)) u_match (
    .probe_line (probe_line),
    .res_vld    (res_vld),
    .res_line   (res_line),
    .hold_vld   (hold_vld),
    .hold_line  (hold_line),
    .hit_res    (hit_res),
    .hit_hold   (hit_hold)
  );

  rxq_pa_decide u_decide (
    .present    (present),
    .use_advice (cfg_use_advice),
    .hold_ack   (cfg_hold_ack),
    .hit_res    (hit_res),
    .hit_hold   (hit_hold),
    .hold_free  (hold_free),
    .act        (act)
  );

  rxq_pa_hold_reg #(.LAW(LAW)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (act == ACT_CAPTURE),
    .line_in (probe_line),
    .gnt     (fill_gnt && hold_vld),
    .vld     (hold_vld),
    .line_q  (hold_line),
    .free    (hold_free)
  );

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= (act != ACT_WAIT);
  end

  assign adv_ack   = ack_q;
  assign fill_req  = hold_vld;
  assign fill_addr = {hold_line, {LOFF{1'b0}}};
endmodule

// File: rtl/rxq_pa_chk.sv
module rxq_pa_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 8,
  localparam int LOFF      = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_use_advice,
  input logic              cfg_hold_ack,
  input logic              adv_valid,
  input logic              adv_ack,
  input logic              fill_req,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              fill_gnt
);
  p_ack_single_r2: assert property (@(posedge clk) disable iff (rst)
    adv_ack |=> !adv_ack);

  p_ignore_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (adv_valid && !adv_ack && !cfg_use_advice) |=> adv_ack);

  p_ignore_nofill_r3: assert property (@(posedge clk) disable iff (rst)
    (adv_valid && !adv_ack && !cfg_use_advice && !fill_req) |=> !fill_req);

  p_align_r4: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> (fill_addr[LOFF-1:0] == '0));

  p_fill_with_ack_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(fill_req) |-> adv_ack);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !fill_gnt) |=> (fill_req && $stable(fill_addr)));

  p_req_release_r5: assert property (@(posedge clk) disable iff (rst)
    (fill_req && fill_gnt && !(adv_valid && !adv_ack && cfg_use_advice)) |=> !fill_req);

  p_prompt_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (adv_valid && !adv_ack && !cfg_hold_ack) |=> adv_ack);
endmodule

bind rxq_prefetch_advice rxq_pa_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_use_advice (cfg_use_advice),
  .cfg_hold_ack   (cfg_hold_ack),
  .adv_valid      (adv_valid),
  .adv_ack        (adv_ack),
  .fill_req       (fill_req),
  .fill_addr      (fill_addr),
  .fill_gnt       (fill_gnt)
);

// File: tb/tb_rxq_prefetch_advice.sv
module tb_rxq_prefetch_advice;
  localparam int AW = 32;
  localparam int LB = 8;
  localparam int NL = 2;
  localparam int LAW = AW - 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_use_advice = 1'b0, cfg_hold_ack = 1'b0;
  logic adv_valid = 1'b0;
  logic [AW-1:0] adv_addr = '0;
  logic adv_ack;
  logic [NL-1:0] res_vld = '0;
  logic [NL*LAW-1:0] res_line = '0;
  logic fill_req;
  logic [AW-1:0] fill_addr;
  logic fill_gnt = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] exp_q[$];
  bit bg_done = 1'b0;
  int bg_wait = 0;

  always #4 clk = ~clk;

  rxq_prefetch_advice #(.ADDR_W(AW), .LINE_BYTES(LB), .NUM_LINES(NL)) dut (
    .clk(clk), .rst(rst), .cfg_use_advice(cfg_use_advice), .cfg_hold_ack(cfg_hold_ack),
    .adv_valid(adv_valid), .adv_addr(adv_addr), .adv_ack(adv_ack),
    .res_vld(res_vld), .res_line(res_line),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_gnt(fill_gnt)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_adv(input logic [AW-1:0] a, output int waits);
    adv_addr  = a;
    adv_valid = 1'b1;
    waits = 0;
    do begin
      @(posedge clk); #1;
      waits++;
    end while (!adv_ack && waits < 50);
    @(posedge clk); #1;
    adv_valid = 1'b0;
  endtask

  task automatic pulse_gnt();
    fill_gnt = 1'b1;
    @(posedge clk); #1;
    fill_gnt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // Scoreboard monitor: every granted request must match the next expected line
  always @(negedge clk) begin
    if (!rst && fill_req && fill_gnt) begin
      if (exp_q.size() == 0) chk("R4 unexpected fill", fill_addr, 32'hx);
      else chk("R4 fill address", fill_addr, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w;
    idle(3);
    // R1 reset state
    chk("R1 ack", adv_ack, 0);
    chk("R1 req", fill_req, 0);
    rst = 1'b0;
    idle(1);

    // R3 ignored advice
    send_adv(32'h0000_0100, w);
    chk("R2 ack latency", w, 1);
    idle(2);
    chk("R3 no fill", fill_req, 0);
    chk("R2 ack single", adv_ack, 0);

    // R4 capture with alignment (prompt mode)
    cfg_use_advice = 1'b1;
    exp_q.push_back(32'h1234_5670);
    send_adv(32'h1234_5675, w);
    chk("R4 req", fill_req, 1);
    chk("R4 aligned addr", fill_addr, 32'h1234_5670);
    idle(3);
    chk("R5 held", fill_req, 1);
    chk("R5 stable", fill_addr, 32'h1234_5670);

    // R6 prompt mode drop while busy
    send_adv(32'h0000_2000, w);
    chk("R6 prompt ack", w, 1);
    chk("R6 pending kept", fill_addr, 32'h1234_5670);
    pulse_gnt();
    chk("R5 release", fill_req, 0);
    idle(2);
    chk("R6 dropped advice no fill", fill_req, 0);

    // R8 resident hit, and invalid entry does not hit
    res_vld = 2'b01;
    res_line[0 +: LAW] = LAW'(32'h3000 >> 3);
    res_line[LAW +: LAW] = LAW'(32'h3100 >> 3);
    send_adv(32'h0000_3004, w);
    idle(1);
    chk("R8 hit absorbed", fill_req, 0);
    exp_q.push_back(32'h0000_3100);
    send_adv(32'h0000_3107, w);
    chk("R8 invalid entry misses", fill_req, 1);
    pulse_gnt();

    // R9 duplicate of pending line
    exp_q.push_back(32'h0000_4000);
    send_adv(32'h0000_4000, w);
    send_adv(32'h0000_4006, w);
    chk("R9 ack", w, 1);
    chk("R9 addr", fill_addr, 32'h0000_4000);
    pulse_gnt();
    idle(1);
    chk("R9 single fill", fill_req, 0);

    // R7 guaranteed mode, R10 same-edge reuse
    cfg_hold_ack = 1'b1;
    exp_q.push_back(32'h0000_5000);
    send_adv(32'h0000_5000, w);
    exp_q.push_back(32'h0000_6008);
    fork
      begin
        send_adv(32'h0000_6008, bg_wait);
        bg_done = 1'b1;
      end
    join_none
    idle(5);
    chk("R7 ack withheld", adv_ack, 0);
    chk("R7 pending kept", fill_addr, 32'h0000_5000);
    pulse_gnt();
    chk("R10 no gap", fill_req, 1);
    chk("R10 new addr", fill_addr, 32'h0000_6008);
    wait (bg_done);
    #1;
    chk("R7 waited", bg_wait > 5, 1);
    pulse_gnt();
    chk("R5 release", fill_req, 0);

    // R3 in guaranteed mode
    cfg_use_advice = 1'b0;
    send_adv(32'h0000_7000, w);
    chk("R3 guaranteed mode ack", w, 1);
    idle(2);
    chk("R3 no fill", fill_req, 0);

    chk("R4 scoreboard empty", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule